// File: doc/BRIEF.md
# Single-Instruction Move Processor Core

This core is an 8-bit processor with no opcodes. Its only operation copies a byte from one bus address to another. An instruction is two consecutive bytes in memory: a source address, then a destination address. Arithmetic, logic and branching come from moves that target a few fixed addresses near the top of the address space:

- Two of those addresses hold the operand registers of a built-in adder and NAND unit.
- Two others load the program counter, one always and one only when the adder's carry is set.

The core drives an external address bus, write data, and separate strobes for instruction fetch, data read and data write. It also raises a one-clock jump pulse so that an external memory pager can latch a new page when control transfers.

An instruction always takes eight clocks, arranged as four machine cycles of two clocks each. The clocks are counted from 0 to 7 within an instruction, and addresses below are given for the default width W = 8:

- Clocks 0–1: fetch the source address at PC.
- Clocks 2–3: read the source into the data register, and advance PC.
- Clocks 4–5: fetch the destination address.
- Clocks 6–7: deposit. The write strobe is asserted only in the final clock, after the address and data have been stable for one clock.

Register writes inside the core, including any PC load, take effect on the clock edge that ends the deposit.

Top module: `mover_core`

## Requirements
- R1: Each instruction takes exactly 8 clocks. The bus address is PC in clocks 0–1, the fetched source address in clocks 2–3, PC+1 in clocks 4–5 and the fetched destination address in clocks 6–7. Without a jump, the next instruction starts at PC+2.
- R2: `mem_fetch` is high in clocks 0, 1, 4 and 5. `mem_rd` is high in clocks 2 and 3. `mem_wr` is high only in clock 7. At most one of the three is high at any time, so each instruction makes exactly one data read and one data write.
- R3: A move whose destination is 0xFF loads the moved byte into PC. The next instruction is fetched from that byte, and `jump_pulse` is high for exactly its first clock.
- R4: A move whose destination is 0xFE loads PC only if `carry_flag` is 1. Otherwise execution continues at PC+2 and `jump_pulse` stays low.
- R5: A move whose destination is 0xF8 loads operand P, and a move whose destination is 0xF9 loads operand Q.
- R6: A source address of 0xF8 yields (P+Q) mod 256, and 0xF9 yields NOT(P AND Q). Every other source address, including 0xFA–0xFF, yields `mem_rdata`.
- R7: `carry_flag` is the carry out of P+Q. It changes only at the end of a write to P or Q, and is unaffected by moves to any other address.
- R8: While `rst` is high, and in the first clock after it is released, PC, the address register, the data register, P, Q and carry are 0. The bus address is 0x00, `mem_fetch` is 1, and `mem_rd`, `mem_wr` and `jump_pulse` are 0.
- R9: `mem_addr` and `mem_wdata` hold the destination and the moved byte in both clock 6 and clock 7, and do not change while `mem_wr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 8 | Registered bus address |
| mem_wdata | output | 8 | Registered write data (the data register) |
| mem_rdata | input | 8 | Read data from memory or devices |
| mem_fetch | output | 1 | Instruction byte fetch strobe |
| mem_rd | output | 1 | Data read strobe |
| mem_wr | output | 1 | Data write strobe |
| jump_pulse | output | 1 | One clock high at the start of an instruction reached by a taken jump |
| carry_flag | output | 1 | Carry out of P+Q |

## Verification
Properties are checked on every cycle:
- The three strobes are mutually exclusive.
- Each write follows the source read by a fixed distance.
- The bus is stable through the write clock.
- The PC advances by one between the two fetches of an instruction.
- Carry and the jump pulse change only right after a write clock.

Only the bench scenarios can show the values themselves. They sweep the adder and NAND results and the carry over a grid of operand pairs. They confirm that the conditional jump is taken or skipped according to carry. They confirm that ordinary reads of the register space come from the bus, and that a jump lands on the moved byte.

// File: rtl/mvc_pkg.sv
package mvc_pkg;

  typedef enum logic [2:0] {
    PH_SRC_ADR     = 3'd0,
    PH_SRC_ADR_LAT = 3'd1,
    PH_SRC_RD      = 3'd2,
    PH_SRC_RD_LAT  = 3'd3,
    PH_DST_ADR     = 3'd4,
    PH_DST_ADR_LAT = 3'd5,
    PH_DST_SET     = 3'd6,
    PH_DST_WR      = 3'd7
  } ph_t;

  typedef struct packed {
    logic fetch;
    logic rd;
    logic wr;
  } strobe_t;

  function automatic strobe_t strobes_for(ph_t ph);
    strobe_t s;
    s.fetch = (ph == PH_SRC_ADR) || (ph == PH_SRC_ADR_LAT) ||
              (ph == PH_DST_ADR) || (ph == PH_DST_ADR_LAT);
    s.rd    = (ph == PH_SRC_RD) || (ph == PH_SRC_RD_LAT);
    s.wr    = (ph == PH_DST_WR);
    return s;
  endfunction

endpackage

// File: rtl/mvc_sequencer.sv
module mvc_sequencer
  import mvc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  output ph_t     ph,
  output strobe_t strb
);

  ph_t ph_nxt;

  always_comb ph_nxt = ph_t'(ph + 3'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= PH_SRC_ADR;
      strb <= strobes_for(PH_SRC_ADR);
    end else begin
      ph   <= ph_nxt;
      strb <= strobes_for(ph_nxt);
    end
  end

endmodule

// File: rtl/mvc_decode.sv
module mvc_decode
  import mvc_pkg::*;
#(
  parameter int W = 8
) (
  input  ph_t          ph,
  input  logic [W-1:0] addr,
  input  logic         carry,
  output logic         wr_p,
  output logic         wr_q,
  output logic         take_jump,
  output logic         rd_sum,
  output logic         rd_nand
);

  localparam logic [W-1:0] ADR_JMP  = {W{1'b1}};
  localparam logic [W-1:0] ADR_JC   = ADR_JMP - W'(1);
  localparam logic [W-1:0] ADR_OPP  = ADR_JMP - W'(7);
  localparam logic [W-1:0] ADR_OPQ  = ADR_JMP - W'(6);

  logic at_deposit;

  always_comb begin
    at_deposit = (ph == PH_DST_WR);
    wr_p       = at_deposit && (addr == ADR_OPP);
    wr_q       = at_deposit && (addr == ADR_OPQ);
    take_jump  = at_deposit &&
                 ((addr == ADR_JMP) || ((addr == ADR_JC) && carry));
    rd_sum     = (addr == ADR_OPP);
    rd_nand    = (addr == ADR_OPQ);
  end

endmodule

// File: rtl/mvc_alu.sv
module mvc_alu #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_p,
  input  logic         wr_q,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] sum,
  output logic [W-1:0] nand_o,
  output logic         carry
);

  logic [W-1:0] op_p, op_q;
  logic [W:0]   sum_new_p, sum_new_q;

  always_comb begin
    sum       = op_p + op_q;
    nand_o    = ~(op_p & op_q);
    sum_new_p = {1'b0, wdata} + {1'b0, op_q};
    sum_new_q = {1'b0, op_p} + {1'b0, wdata};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_p  <= '0;
      op_q  <= '0;
      carry <= 1'b0;
    end else if (wr_p) begin
      op_p  <= wdata;
      carry <= sum_new_p[W];
    end else if (wr_q) begin
      op_q  <= wdata;
      carry <= sum_new_q[W];
    end
  end

endmodule

// File: rtl/mvc_datapath.sv
module mvc_datapath
  import mvc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  ph_t          ph,
  input  logic [W-1:0] rdata,
  input  logic [W-1:0] alu_sum,
  input  logic [W-1:0] alu_nand,
  input  logic         rd_sum,
  input  logic         rd_nand,
  input  logic         take_jump,
  output logic [W-1:0] addr_r,
  output logic [W-1:0] data_r,
  output logic [W-1:0] bus_addr,
  output logic         jump_q
);

  logic [W-1:0] pc, pc_inc, src_val;

  always_comb begin
    pc_inc = pc + W'(1);
    if (rd_sum)       src_val = alu_sum;
    else if (rd_nand) src_val = alu_nand;
    else              src_val = rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= '0;
      addr_r   <= '0;
      data_r   <= '0;
      bus_addr <= '0;
      jump_q   <= 1'b0;
    end else begin
      jump_q <= 1'b0;
      unique case (ph)
        PH_SRC_ADR_LAT, PH_DST_ADR_LAT: begin
          addr_r   <= rdata;
          bus_addr <= rdata;
        end
        PH_SRC_RD_LAT: begin
          data_r   <= src_val;
          pc       <= pc_inc;
          bus_addr <= pc_inc;
        end
        PH_DST_WR: begin
          if (take_jump) begin
            pc       <= data_r;
            bus_addr <= data_r;
            jump_q   <= 1'b1;
          end else begin
            pc       <= pc_inc;
            bus_addr <= pc_inc;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/mover_core.sv
module mover_core
  import mvc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic [W-1:0] mem_rdata,
  output logic         mem_fetch,
  output logic         mem_rd,
  output logic         mem_wr,
  output logic         jump_pulse,
  output logic         carry_flag
);

  ph_t          ph;
  strobe_t      strb;
  logic [W-1:0] addr_r, data_r, alu_sum, alu_nand;
  logic         wr_p, wr_q, take_jump, rd_sum, rd_nand, carry;

  mvc_sequencer u_seq (
    .clk (clk),
    .rst (rst),
    .ph  (ph),
    .strb(strb)
  );

  mvc_decode #(.W(W)) u_dec (
    .ph       (ph),
    .addr     (addr_r),
    .carry    (carry),
    .wr_p     (wr_p),
    .wr_q     (wr_q),
    .take_jump(take_jump),
    .rd_sum   (rd_sum),
    .rd_nand  (rd_nand)
  );

  mvc_alu #(.W(W)) u_alu (
    .clk   (clk),
    .rst   (rst),
    .wr_p  (wr_p),
    .wr_q  (wr_q),
    .wdata (data_r),
    .sum   (alu_sum),
    .nand_o(alu_nand),
    .carry (carry)
  );

  mvc_datapath #(.W(W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ph       (ph),
    .rdata    (mem_rdata),
    .alu_sum  (alu_sum),
    .alu_nand (alu_nand),
    .rd_sum   (rd_sum),
    .rd_nand  (rd_nand),
    .take_jump(take_jump),
    .addr_r   (addr_r),
    .data_r   (data_r),
    .bus_addr (mem_addr),
    .jump_q   (jump_pulse)
  );

  assign mem_wdata  = data_r;
  assign mem_fetch  = strb.fetch;
  assign mem_rd     = strb.rd;
  assign mem_wr     = strb.wr;
  assign carry_flag = carry;

endmodule

// File: rtl/mvc_checker.sv
module mvc_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] mem_addr,
  input logic [W-1:0] mem_wdata,
  input logic         mem_fetch,
  input logic         mem_rd,
  input logic         mem_wr,
  input logic         jump_pulse,
  input logic         carry_flag
);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_fetch, mem_rd, mem_wr})); // R2

  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_wr) |-> $past(mem_rd, 4)); // R2

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_fetch) && $past(mem_rd)) |->
      ((mem_addr - $past(mem_addr, 4)) == W'(1))); // R1

  AST_WR_BUS_STABLE: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> ($stable(mem_addr) && $stable(mem_wdata))); // R9

  AST_JUMP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    jump_pulse |=> !jump_pulse); // R3

  AST_JUMP_AFTER_WR: assert property (@(posedge clk) disable iff (rst)
    jump_pulse |-> ($past(mem_wr) && mem_fetch)); // R3

  AST_CARRY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    !$stable(carry_flag) |-> $past(mem_wr)); // R7

endmodule

bind mover_core mvc_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_fetch (mem_fetch),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .jump_pulse(jump_pulse),
  .carry_flag(carry_flag)
);

// File: tb/sim_mover_core.sv
module sim_mover_core;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic       mem_fetch, mem_rd, mem_wr, jump_pulse, carry_flag;
  logic [7:0] mem [256];
  int         n_chk = 0;
  int         n_fail = 0;

  always #4 clk = ~clk;

  mover_core #(.W(8)) u0 (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_fetch (mem_fetch),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .jump_pulse(jump_pulse),
    .carry_flag(carry_flag)
  );

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) if (mem_wr) mem[mem_addr] <= mem_wdata;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  endtask

  task automatic put_move(input int at, input int src, input int dst);
    mem[at]     = 8'(src);
    mem[at + 1] = 8'(dst);
  endtask

  task automatic start();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic alu_case(input int a, input int b);
    @(negedge clk);
    rst = 1'b1;
    clear_mem();
    mem[8'h60] = 8'(a);
    mem[8'h61] = 8'(b);
    put_move(0, 8'h60, 8'hF8);
    put_move(2, 8'h61, 8'hF9);
    put_move(4, 8'hF8, 8'h90);
    put_move(6, 8'hF9, 8'h91);
    start();
    run(32);
    chk("R6 sum", mem[8'h90], (a + b) & 255);
    chk("R6 nand", mem[8'h91], (~(a & b)) & 255);
    chk("R7 carry", carry_flag, (a + b) > 255 ? 1 : 0);
  endtask

  task automatic jc_case(input int a, input int b);
    int c;
    c = ((a + b) > 255) ? 1 : 0;
    @(negedge clk);
    rst = 1'b1;
    clear_mem();
    mem[8'h60] = 8'(a);
    mem[8'h61] = 8'(b);
    mem[8'h62] = 8'h20;
    mem[8'h63] = 8'hAA;
    mem[8'h64] = 8'h55;
    put_move(0, 8'h60, 8'hF8);
    put_move(2, 8'h61, 8'hF9);
    put_move(4, 8'h62, 8'hFE);
    put_move(6, 8'h63, 8'h92);
    put_move(8'h20, 8'h64, 8'h92);
    start();
    run(24);
    chk("R4 pulse", jump_pulse, c);
    chk("R4 next pc", mem_addr, c ? 8'h20 : 8'h06);
    run(8);
    chk("R4 path", mem[8'h92], c ? 8'h55 : 8'hAA);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R8 reset state and R1/R2/R9 bus sequence of a plain move
    clear_mem();
    mem[8'h40] = 8'h5A;
    put_move(0, 8'h40, 8'h80);
    start();
    chk("R8 addr", mem_addr, 0);
    chk("R8 fetch", mem_fetch, 1);
    chk("R8 rd", mem_rd, 0);
    chk("R8 wr", mem_wr, 0);
    chk("R8 jump", jump_pulse, 0);
    chk("R8 carry", carry_flag, 0);
    chk("R8 wdata", mem_wdata, 0);
    for (int k = 0; k < 8; k++) begin
      int ea;
      ea = (k < 2) ? 8'h00 : (k < 4) ? 8'h40 : (k < 6) ? 8'h01 : 8'h80;
      chk("R1 addr", mem_addr, ea);
      chk("R2 fetch", mem_fetch, (k == 0 || k == 1 || k == 4 || k == 5) ? 1 : 0);
      chk("R2 rd", mem_rd, (k == 2 || k == 3) ? 1 : 0);
      chk("R2 wr", mem_wr, (k == 7) ? 1 : 0);
      if (k >= 6) chk("R9 wdata", mem_wdata, 8'h5A);
      run(1);
    end
    chk("R1 moved", mem[8'h80], 8'h5A);
    chk("R1 next", mem_addr, 8'h02);

    // R5 R6 R7 operand grid
    for (int ai = 0; ai < 16; ai++)
      for (int bi = 0; bi < 12; bi++)
        alu_case(ai * 17, bi * 23);
    alu_case(255, 1);
    alu_case(192, 64);
    alu_case(128, 127);

    // R3 unconditional jump
    @(negedge clk);
    rst = 1'b1;
    clear_mem();
    mem[8'h62] = 8'h20;
    mem[8'h63] = 8'hAA;
    mem[8'h64] = 8'h55;
    put_move(0, 8'h62, 8'hFF);
    put_move(2, 8'h64, 8'h92);
    put_move(8'h20, 8'h63, 8'h92);
    start();
    run(7);
    chk("R3 no early pulse", jump_pulse, 0);
    run(1);
    chk("R3 pulse", jump_pulse, 1);
    chk("R3 target", mem_addr, 8'h20);
    run(1);
    chk("R3 pulse width", jump_pulse, 0);
    run(7);
    chk("R3 landed", mem[8'h92], 8'hAA);
    chk("R3 after", mem_addr, 8'h22);

    // R4 conditional jump
    jc_case(8'hC0, 8'h40);
    jc_case(8'hC0, 8'h3F);
    jc_case(8'hFF, 8'h01);
    jc_case(8'h00, 8'h00);

    // R7 hold on other writes, R6 bus read of register space, R5 Q reload
    @(negedge clk);
    rst = 1'b1;
    clear_mem();
    mem[8'h60] = 8'hC0;
    mem[8'h61] = 8'h40;
    mem[8'h65] = 8'h00;
    mem[8'hFA] = 8'h77;
    put_move(0, 8'h60, 8'hF8);
    put_move(2, 8'h61, 8'hF9);
    put_move(4, 8'h60, 8'hA0);
    put_move(6, 8'hFA, 8'hA1);
    put_move(8, 8'h65, 8'hF9);
    put_move(10, 8'hF8, 8'hA2);
    start();
    run(16);
    chk("R7 set", carry_flag, 1);
    run(8);
    chk("R7 hold", carry_flag, 1);
    chk("R1 plain", mem[8'hA0], 8'hC0);
    run(8);
    chk("R6 bus reg read", mem[8'hA1], 8'h77);
    chk("R7 hold2", carry_flag, 1);
    run(8);
    chk("R7 clear", carry_flag, 0);
    run(8);
    chk("R5 q reload", mem[8'hA2], 8'hC0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule